// File: doc/BRIEF.md
# Reference-Clock Dependent PHY Tuning Sequencer

This block runs a short, fixed calibration program against a PHY's internal control-register space. It does not drive that space itself. Each tuning write goes out as an address/data request to a separate port master, which reports success or failure. The program has three override writes. The first two are constant. The third carries a receiver-detect measurement time, and that time depends on a 3-bit code for the PHY reference frequency.

Software or a power-up controller pulses `start_i`. If the high-speed lane is selected (`lane_hs_i` = 1), the block latches the frequency code and issues the three writes in order. Each request is held until the master answers. After the last acknowledge the block pulses `done_o` once. If a write fails, the block stops at once and reports `err_o` together with `done_o`. If the super-speed lane is selected (`lane_hs_i` = 0), the block finishes immediately and issues no write.

Top module: `phy_tune_seq`

## Requirements
- R1: While and after reset, `req_o`, `done_o` and `err_o` are 0 until a start is accepted.
- R2: The first request of a sequence has address 0x0015 and data 0xA409. The data is loss-of-signal bias 5 in bits [15:13], override enable in bit 10 and level 9 in bits [4:0].
- R3: The second request has address 0x0012 and data 0xA000. This is transmit boost level 5 in bits [15:13].
- R4: The third request has address 0x1010 and data equal to the measurement time shifted left by 4. The measurement time is 0x20 for code 7 (data 0x0200), 0x4 for codes 3 and 4 (data 0x0040), and 0x8 for every other code (data 0x0080).
- R5: The frequency code is sampled in the cycle `start_i` is accepted. A later change of `freq_code_i` does not change the third write.
- R6: `req_o` stays high, with address and data stable, until the master returns `wr_done_i` or `wr_err_i`. The next request's address and data appear in the cycle after `wr_done_i`, and `req_o` stays high between the steps.
- R7: If `wr_err_i` is seen on any step, no further write is requested. `done_o` and `err_o` are both high for exactly the one cycle after the error.
- R8: A start taken with `lane_hs_i` = 0 raises `done_o` for one cycle in the cycle after start, with `err_o` = 0 and no request.
- R9: After `wr_done_i` on the third write, `done_o` is high for exactly one cycle with `err_o` = 0 and `req_o` = 0.
- R10: `start_i` is ignored while a sequence is in progress. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a calibration sequence (taken when idle) |
| lane_hs_i | input | 1 | 1: high-speed lane, run writes; 0: super-speed lane, finish at once |
| freq_code_i | input | 3 | Reference-frequency code |
| wr_done_i | input | 1 | Port master: current write completed |
| wr_err_i | input | 1 | Port master: current write failed |
| req_o | output | 1 | Write request to the port master |
| addr_o | output | 16 | Control-register address of the request |
| data_o | output | 16 | Write data of the request |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | High with `done_o` when the sequence stopped on a failed write |

## Verification
The assertions assume the port master answers only while `req_o` is high, with a single-cycle `wr_done_i` or `wr_err_i` pulse and never both at once. They also assume the master never answers in the cycle after a response, because the next request only appears then. The bench's master model respects all of this. It waits a random 0 to 3 cycles with the request pending, then raises exactly one response for one cycle and lowers it before sampling. Random codes, lane choices and error positions are mixed with directed runs for every code, for an error on each step, for a changed code after start, and for a start pulse during a run.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 16;
    localparam int CODE_W    = 3;
    localparam int NUM_STEPS = 3;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int MEAS_SH   = 4;

    // Control-register targets of the three override writes
    localparam logic [ADDR_W-1:0] LOS_ADDR   = ADDR_W'(16'h0015);
    localparam logic [ADDR_W-1:0] BOOST_ADDR = ADDR_W'(16'h0012);
    localparam logic [ADDR_W-1:0] RXDET_ADDR = ADDR_W'(16'h1010);

    // Field values
    localparam logic [2:0] LOS_BIAS   = 3'd5;
    localparam logic [4:0] LOS_LEVEL  = 5'd9;
    localparam logic [2:0] BOOST_LVL  = 3'd5;

    // Reference-frequency codes that select non-default timing
    localparam logic [CODE_W-1:0] CODE_19M2 = CODE_W'(3);
    localparam logic [CODE_W-1:0] CODE_20M  = CODE_W'(4);
    localparam logic [CODE_W-1:0] CODE_50M  = CODE_W'(7);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [DATA_W-1:0] los_word();
        logic [DATA_W-1:0] w;
        w = '0;
        w[15:13] = LOS_BIAS;
        w[10]    = 1'b1;
        w[4:0]   = LOS_LEVEL;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] boost_word();
        logic [DATA_W-1:0] w;
        w = '0;
        w[15:13] = BOOST_LVL;
        return w;
    endfunction

    function automatic logic [9:0] meas_time(input logic [CODE_W-1:0] code);
        logic [9:0] t;
        if (code == CODE_50M)
            t = 10'h020;
        else if (code == CODE_20M || code == CODE_19M2)
            t = 10'h004;
        else
            t = 10'h008;
        return t;
    endfunction

    function automatic logic [DATA_W-1:0] rxdet_word(input logic [CODE_W-1:0] code);
        return DATA_W'({meas_time(code), MEAS_SH'(0)});
    endfunction

endpackage

// File: rtl/phy_tune_table.sv
module phy_tune_table
    import phy_tune_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic [CODE_W-1:0] code_i,
    output wr_req_t           req_o
);

    always_comb begin
        if (step_i == STEP_W'(0)) begin
            req_o.addr = LOS_ADDR;
            req_o.data = los_word();
        end else if (step_i == STEP_W'(1)) begin
            req_o.addr = BOOST_ADDR;
            req_o.data = boost_word();
        end else begin
            req_o.addr = RXDET_ADDR;
            req_o.data = rxdet_word(code_i);
        end
    end

endmodule

// File: rtl/phy_tune_ctrl.sv
module phy_tune_ctrl
    import phy_tune_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              lane_hs_i,
    input  logic [CODE_W-1:0] freq_code_i,
    input  logic              wr_done_i,
    input  logic              wr_err_i,
    output logic [STEP_W-1:0] step_o,
    output logic [CODE_W-1:0] code_o,
    output logic              req_o,
    output logic              done_o,
    output logic              err_o
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    seq_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic [CODE_W-1:0] code_q;
    logic              fail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            code_q  <= '0;
            fail_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        code_q  <= freq_code_i;
                        step_q  <= '0;
                        fail_q  <= 1'b0;
                        state_q <= lane_hs_i ? ST_BUSY : ST_FIN;
                    end
                end
                ST_BUSY: begin
                    if (wr_err_i) begin
                        fail_q  <= 1'b1;
                        state_q <= ST_FIN;
                    end else if (wr_done_i) begin
                        if (step_q == LAST_STEP)
                            state_q <= ST_FIN;
                        else
                            step_q <= step_q + STEP_W'(1);
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign step_o = step_q;
    assign code_o = code_q;
    assign req_o  = (state_q == ST_BUSY);
    assign done_o = (state_q == ST_FIN);
    assign err_o  = (state_q == ST_FIN) && fail_q;

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: an error report follows a failed write by one cycle
    a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($past(wr_err_i) && done_o && !req_o));

    // R8: a super-speed start finishes in the next cycle with no request
    a_r8_ss_direct: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_i && !lane_hs_i) |=> (done_o && !req_o && !err_o));

    // R10: a start during a run leaves the latched code alone
    a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
        (req_o && start_i) |=> $stable(code_q));

endmodule

// File: rtl/phy_tune_seq.sv
module phy_tune_seq
    import phy_tune_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              lane_hs_i,
    input  logic [CODE_W-1:0] freq_code_i,
    input  logic              wr_done_i,
    input  logic              wr_err_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o,
    output logic              err_o
);

    logic [STEP_W-1:0] step;
    logic [CODE_W-1:0] code;
    wr_req_t           cur;

    phy_tune_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .lane_hs_i   (lane_hs_i),
        .freq_code_i (freq_code_i),
        .wr_done_i   (wr_done_i),
        .wr_err_i    (wr_err_i),
        .step_o      (step),
        .code_o      (code),
        .req_o       (req_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    phy_tune_table u_table (
        .step_i (step),
        .code_i (code),
        .req_o  (cur)
    );

    assign addr_o = cur.addr;
    assign data_o = cur.data;

    // R6: a pending request holds its address and data
    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_o && !wr_done_i && !wr_err_i) |=> (req_o && $stable(addr_o) && $stable(data_o)));

    // R2: every new sequence opens with the loss-of-signal override
    a_r2_first_write: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> (addr_o == LOS_ADDR && data_o == los_word()));

    // R1: nothing is reported in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!req_o && !done_o && !err_o));

endmodule

// File: tb/phy_tune_seq_bench.sv
`timescale 1ns/1ps
module phy_tune_seq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, lane_hs_i, wr_done_i, wr_err_i;
    logic [2:0]  freq_code_i;
    logic        req_o, done_o, err_o;
    logic [15:0] addr_o, data_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    phy_tune_seq u_phy_tune_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .lane_hs_i(lane_hs_i),
        .freq_code_i(freq_code_i), .wr_done_i(wr_done_i), .wr_err_i(wr_err_i),
        .req_o(req_o), .addr_o(addr_o), .data_o(data_o),
        .done_o(done_o), .err_o(err_o)
    );

    function automatic logic [15:0] exp_addr(input int step);
        case (step)
            0:       return 16'h0015;
            1:       return 16'h0012;
            default: return 16'h1010;
        endcase
    endfunction

    function automatic logic [15:0] exp_data(input int step, input logic [2:0] code);
        if (step == 0) return 16'hA409;
        if (step == 1) return 16'hA000;
        case (code)
            3'd7:       return 16'h0200;
            3'd3, 3'd4: return 16'h0040;
            default:    return 16'h0080;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One sequence; err_step 0..2 injects a failure there, 3 means none.
    // new_code >= 0 replaces the code input after start (R5).
    task automatic run_seq(input logic [2:0] code, input bit hs, input int err_step,
                           input int new_code, input bit busy_start);
        @(negedge clk);
        start_i = 1'b1; lane_hs_i = hs; freq_code_i = code;
        @(negedge clk);
        start_i = 1'b0;
        if (new_code >= 0) freq_code_i = 3'(new_code);
        if (!hs) begin
            chk("R8 done", {31'd0, done_o}, 32'd1);
            chk("R8 req", {31'd0, req_o}, 32'd0);
            chk("R8 err", {31'd0, err_o}, 32'd0);
            @(negedge clk);
            chk("R8 done width", {31'd0, done_o}, 32'd0);
            return;
        end
        for (int s = 0; s < 3; s++) begin
            int lat;
            lat = int'($urandom_range(0, 3));
            for (int w = 0; w <= lat; w++) begin
                chk(s == 0 ? "R2 req" : (s == 1 ? "R3 req" : "R4 req"), {31'd0, req_o}, 32'd1);
                chk(s == 0 ? "R2 addr" : (s == 1 ? "R3 addr" : "R4 addr"), {16'd0, addr_o}, {16'd0, exp_addr(s)});
                chk(s == 2 ? "R4/R5 data" : (s == 0 ? "R2 data" : "R3 data"), {16'd0, data_o}, {16'd0, exp_data(s, code)});
                chk("R6 no early done", {31'd0, done_o}, 32'd0);
                if (w < lat) begin
                    if (busy_start && s == 1 && w == 0) begin
                        start_i = 1'b1; lane_hs_i = 1'b0; freq_code_i = ~code;
                    end
                    @(negedge clk);
                    start_i = 1'b0; lane_hs_i = hs;
                end
            end
            if (s == err_step) wr_err_i = 1'b1; else wr_done_i = 1'b1;
            @(negedge clk);
            wr_err_i = 1'b0; wr_done_i = 1'b0;
            if (s == err_step) begin
                chk("R7 done", {31'd0, done_o}, 32'd1);
                chk("R7 err", {31'd0, err_o}, 32'd1);
                chk("R7 req", {31'd0, req_o}, 32'd0);
                @(negedge clk);
                chk("R7 stop", {29'd0, req_o, done_o, err_o}, 32'd0);
                return;
            end
        end
        chk("R9 done", {31'd0, done_o}, 32'd1);
        chk("R9 err", {31'd0, err_o}, 32'd0);
        chk("R9 req", {31'd0, req_o}, 32'd0);
        @(negedge clk);
        chk("R9 pulse width", {29'd0, req_o, done_o, err_o}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0123));
        rst = 1'b1; start_i = 1'b0; lane_hs_i = 1'b1; freq_code_i = 3'd0;
        wr_done_i = 1'b0; wr_err_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {29'd0, req_o, done_o, err_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle outputs", {29'd0, req_o, done_o, err_o}, 32'd0);

        // Directed: every code on the HS lane (R4)
        for (int c = 0; c < 8; c++) run_seq(3'(c), 1'b1, 3, -1, 1'b0);
        // Error on each step (R7)
        for (int e = 0; e < 3; e++) run_seq(3'd5, 1'b1, e, -1, 1'b0);
        // SS lane (R8)
        run_seq(3'd7, 1'b0, 3, -1, 1'b0);
        // Code change after start (R5): latched 7, input moves to 2
        run_seq(3'd7, 1'b1, 3, 2, 1'b0);
        run_seq(3'd4, 1'b1, 3, 0, 1'b0);
        // Start during a run is ignored (R10)
        run_seq(3'd3, 1'b1, 3, -1, 1'b1);
        run_seq(3'd7, 1'b1, 2, -1, 1'b1);

        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic [2:0] c;
            bit h;
            int e, nc;
            c  = 3'($urandom_range(0, 7));
            h  = ($urandom_range(0, 4) != 0);
            e  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 2)) : 3;
            nc = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 7)) : -1;
            run_seq(c, h, e, nc, ($urandom_range(0, 3) == 0));
            repeat (int'($urandom_range(0, 2))) @(negedge clk);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule